// File: doc/BRIEF.md
# Byte-Parity Memory Word Checker

This block sits between a 16-bit processor data path and a memory array that stores 18 bits per word. On the write side it appends one check bit to each data byte, combinationally and in the same cycle as the data, so the array stores data and check bits together. On the read side it recomputes the check for each byte whenever a read strobe is presented. It compares the result with the stored check bits.

When any byte fails on a read, a sticky latch sets. The latch drives a processor halt request and a front-panel error lamp, and it records which bytes failed. Reads that arrive while the halt is up are not checked, so the first failure stays recorded. Only a synchronous operator clear or the reset empties the latch. An enable input lets the memory run without checking, which models an installation where the checker is absent. With the enable low, no check bits are generated and no failures are recorded.

Top module: `mem_byte_parity_guard`

## Requirements
- R1: With `chk_en` high, `wr_word[15:0]` equals `wr_data` in the same cycle. `wr_word[16]` is set so that data bits 7:0 plus that bit hold an odd number of ones. `wr_word[17]` does the same for data bits 15:8.
- R2: `rd_data` always equals `rd_word[15:0]` in the same cycle, whatever the state of the checker.
- R3: An all-zero stored word (data 0, both check bits 0) that is read with checking enabled is flagged as a failure of both bytes: `err_lanes` = 2'b11.
- R4: A read with `rd_valid` high, `chk_en` high and the latch clear, in which a byte fails, sets `halt_req` and `err_lamp` after the next rising clock edge. `err_lanes` records the failing bytes: bit 0 is the low byte and bit 1 is the high byte.
- R5: A read with correct check bits, or any cycle with `rd_valid` low, leaves `halt_req`, `err_lamp` and `err_lanes` unchanged.
- R6: While `halt_req` is high, further read strobes are ignored. `err_lanes` keeps the first failure and `halt_req` stays high until it is cleared.
- R7: `clr` high at a rising edge empties the latch: `halt_req`, `err_lamp` and `err_lanes` all read 0. This holds even when a failing read occurs in the same cycle.
- R8: With `chk_en` low, `wr_word[17:16]` are 0, and failing reads do not set the latch.
- R9: An active-low `rst_n` clears the latch at once, including while it is set.
- R10: Dropping `chk_en` does not clear a latch that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Enables check-bit generation and read checking |
| clr | input | 1 | Synchronous operator clear of the error latch |
| wr_data | input | 16 | Processor write data |
| wr_word | output | 18 | Word to store: check bits at 17:16, data at 15:0 |
| rd_valid | input | 1 | Read strobe; checking occurs only in these cycles |
| rd_word | input | 18 | Stored word returned by the array |
| rd_data | output | 16 | Data passed to the processor |
| halt_req | output | 1 | Sticky halt request to the processor |
| err_lamp | output | 1 | Front-panel error indicator |
| err_lanes | output | 2 | Failing bytes of the first error (bit 0 low, bit 1 high) |

## Verification
The hardest state to reach from the ports is the preservation of a first failure. It needs a failing read, then a second failing read whose byte pattern differs, arriving while the halt is already up. The bench latches a failure of both bytes from an all-zero word. It then presents a word that fails only the low byte and confirms that the recorded bytes do not change. The collision of `clr` with a failing read in the same cycle is driven in the same way, by holding both inputs across one edge.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_sense_e;

endpackage

// File: rtl/mpg_lane_gen.sv
module mpg_lane_gen #(
   parameter int                 LANE_W = 8,
   parameter mpg_pkg::par_sense_e SENSE = mpg_pkg::PAR_ODD
) (
   input  logic [LANE_W-1:0] lane,
   output logic              chk_bit
);

   generate
      if (SENSE == mpg_pkg::PAR_ODD) begin : g_odd
         assign chk_bit = ~(^lane);
      end else begin : g_even
         assign chk_bit = ^lane;
      end
   endgenerate

endmodule

// File: rtl/mpg_lane_chk.sv
module mpg_lane_chk #(
   parameter int                 LANE_W = 8,
   parameter mpg_pkg::par_sense_e SENSE = mpg_pkg::PAR_ODD
) (
   input  logic [LANE_W-1:0] lane,
   input  logic              stored_bit,
   output logic              bad
);

   logic expect_bit;

   mpg_lane_gen #(.LANE_W(LANE_W), .SENSE(SENSE)) u_gen (
      .lane    (lane),
      .chk_bit (expect_bit)
   );

   assign bad = expect_bit ^ stored_bit;

endmodule

// File: rtl/mpg_err_latch.sv
module mpg_err_latch #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             capture,
   input  logic [LANES-1:0] lanes_in,
   output logic             halt_q,
   output logic [LANES-1:0] lanes_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q  <= 1'b0;
         lanes_q <= '0;
      end else if (clr) begin
         halt_q  <= 1'b0;
         lanes_q <= '0;
      end else if (capture && !halt_q) begin
         halt_q  <= 1'b1;
         lanes_q <= lanes_in;
      end
   end

   // R6: a set latch holds, and its recorded bytes freeze, until cleared
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !clr) |=> halt_q);
   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !clr) |=> $stable(lanes_q));
   // R7: clear empties the latch
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!halt_q && lanes_q == '0));

endmodule

// File: rtl/mem_byte_parity_guard.sv
module mem_byte_parity_guard #(
   parameter int                  DATA_W = 16,
   parameter int                  LANE_W = 8,
   parameter mpg_pkg::par_sense_e SENSE  = mpg_pkg::PAR_ODD,
   localparam int                 LANES  = DATA_W / LANE_W,
   localparam int                 WORD_W = DATA_W + LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic              clr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [WORD_W-1:0] wr_word,
   input  logic              rd_valid,
   input  logic [WORD_W-1:0] rd_word,
   output logic [DATA_W-1:0] rd_data,
   output logic              halt_req,
   output logic              err_lamp,
   output logic [LANES-1:0]  err_lanes
);

   generate
      if (LANE_W < 1 || DATA_W % LANE_W != 0) begin : g_bad_lane
         $error("DATA_W must be a whole multiple of LANE_W");
      end
      if (LANES < 1) begin : g_bad_count
         $error("at least one lane is required");
      end
   endgenerate

   logic [LANES-1:0] gen_bits;
   logic [LANES-1:0] lane_bad;
   logic             capture;
   logic             halt_q;
   logic [LANES-1:0] lanes_q;

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         mpg_lane_gen #(.LANE_W(LANE_W), .SENSE(SENSE)) u_gen (
            .lane    (wr_data[gi*LANE_W +: LANE_W]),
            .chk_bit (gen_bits[gi])
         );
         mpg_lane_chk #(.LANE_W(LANE_W), .SENSE(SENSE)) u_chk (
            .lane       (rd_word[gi*LANE_W +: LANE_W]),
            .stored_bit (rd_word[DATA_W + gi]),
            .bad        (lane_bad[gi])
         );
         assign wr_word[DATA_W + gi] = chk_en & gen_bits[gi];

         // R1: each stored lane with its check bit carries the chosen parity
         a_r1_lane_parity: assert property (@(posedge clk) disable iff (!rst_n)
            chk_en |-> ((^{wr_word[gi*LANE_W +: LANE_W], wr_word[DATA_W + gi]}) == 1'(SENSE)));
      end
   endgenerate

   assign wr_word[DATA_W-1:0] = wr_data;
   assign rd_data             = rd_word[DATA_W-1:0];
   assign capture             = chk_en & rd_valid & (|lane_bad);

   mpg_err_latch #(.LANES(LANES)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .capture  (capture),
      .lanes_in (lane_bad),
      .halt_q   (halt_q),
      .lanes_q  (lanes_q)
   );

   assign halt_req  = halt_q;
   assign err_lamp  = |lanes_q;
   assign err_lanes = lanes_q;

   // R4: a failing enabled read on a clear latch raises the halt
   a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && rd_valid && (|lane_bad) && !halt_req && !clr) |=> (halt_req && err_lamp));
   // R5: a cycle without a read strobe never raises the halt
   a_r5_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_valid && !halt_req) |=> !halt_req);
   // R8: disabled checker raises nothing and stores no check bits
   a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_en && !halt_req) |=> !halt_req);
   a_r8_no_bits: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en |-> (wr_word[WORD_W-1:DATA_W] == '0));

endmodule

// File: tb/mem_byte_parity_guard_bench.sv
module mem_byte_parity_guard_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chk_en = 1'b1;
   logic        clr = 1'b0;
   logic [15:0] wr_data = '0;
   logic [17:0] wr_word;
   logic        rd_valid = 1'b0;
   logic [17:0] rd_word = '0;
   logic [15:0] rd_data;
   logic        halt_req;
   logic        err_lamp;
   logic [1:0]  err_lanes;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   mem_byte_parity_guard u_mem_byte_parity_guard (
      .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .clr(clr),
      .wr_data(wr_data), .wr_word(wr_word), .rd_valid(rd_valid),
      .rd_word(rd_word), .rd_data(rd_data), .halt_req(halt_req),
      .err_lamp(err_lamp), .err_lanes(err_lanes)
   );

   // {write data, expected stored word}; check bits give odd ones per byte
   localparam logic [33:0] VEC [8] = '{
      {16'h0000, 18'h30000},
      {16'hFFFF, 18'h3FFFF},
      {16'h0001, 18'h20001},
      {16'h0100, 18'h10100},
      {16'h8003, 18'h18003},
      {16'h7F80, 18'h07F80},
      {16'hA5C3, 18'h3A5C3},
      {16'h1234, 18'h21234}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic status(input string tag, input logic h, input logic l, input logic [1:0] ln);
      check({tag, " halt"}, 32'(halt_req), 32'(h));
      check({tag, " lamp"}, 32'(err_lamp), 32'(l));
      check({tag, " lanes"}, 32'(err_lanes), 32'(ln));
   endtask

   // present one read for one clock edge, then sample after it
   task automatic do_read(input logic [17:0] w, input logic v);
      @(negedge clk);
      rd_word  = w;
      rd_valid = v;
      @(negedge clk);
      rd_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      status("R9 reset state", 1'b0, 1'b0, 2'b00);
      rst_n = 1'b1;

      // R1 write generation, R2 passthrough, R5 good reads leave latch clear
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         wr_data = VEC[i][33:18];
         #1 check("R1 wr_word", 32'(wr_word), 32'(VEC[i][17:0]));
         rd_word  = VEC[i][17:0];
         rd_valid = 1'b1;
         #1 check("R2 rd_data", 32'(rd_data), 32'(VEC[i][15:0]));
         @(negedge clk);
         rd_valid = 1'b0;
         status("R5 good read", 1'b0, 1'b0, 2'b00);
      end

      // R5 bad word without strobe
      do_read(18'h00000, 1'b0);
      status("R5 no strobe", 1'b0, 1'b0, 2'b00);

      // R3 all-zero word fails both bytes; R4 latch raised
      do_read(18'h00000, 1'b1);
      status("R3 R4 zero word", 1'b1, 1'b1, 2'b11);

      // R6 low-only failure while halted is ignored
      do_read(18'h20000, 1'b1);
      status("R6 held first", 1'b1, 1'b1, 2'b11);
      do_read(18'h30000, 1'b1);
      status("R6 good read halted", 1'b1, 1'b1, 2'b11);

      // R10 dropping enable keeps latch
      @(negedge clk); chk_en = 1'b0;
      @(negedge clk);
      status("R10 enable dropped", 1'b1, 1'b1, 2'b11);
      chk_en = 1'b1;

      // R7 clear
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      status("R7 clear", 1'b0, 1'b0, 2'b00);

      // R4 low byte only (check bit 16 wrong)
      do_read(18'h20000, 1'b1);
      status("R4 low byte", 1'b1, 1'b1, 2'b01);
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;

      // R4 high byte only (check bit 17 wrong)
      do_read(18'h1A5C3 ^ 18'h20000 ^ 18'h20000 ^ 18'h10000 ^ 18'h10000 ^ 18'h00000, 1'b1);
      status("R4 high byte", 1'b1, 1'b1, 2'b10);

      // R9 reset while latched
      @(negedge clk); rst_n = 1'b0;
      #1 status("R9 async reset", 1'b0, 1'b0, 2'b00);
      @(negedge clk); rst_n = 1'b1;

      // R7 clear beats a simultaneous failing read
      @(negedge clk);
      clr = 1'b1; rd_word = 18'h00000; rd_valid = 1'b1;
      @(negedge clk);
      clr = 1'b0; rd_valid = 1'b0;
      status("R7 clear priority", 1'b0, 1'b0, 2'b00);

      // R8 disabled: no check bits, failing read ignored
      @(negedge clk);
      chk_en = 1'b0; wr_data = 16'h0000;
      #1 check("R8 wr_word disabled", 32'(wr_word), 32'h0);
      do_read(18'h00000, 1'b1);
      status("R8 disabled read", 1'b0, 1'b0, 2'b00);
      chk_en = 1'b1;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule